// File: doc/BRIEF.md
# Attribute-Driven Pixel Colour Generator

This block sits in a raster video pipeline. It takes one cell at a time: a one-bit-per-pixel bitmap byte and a companion attribute byte. From these it produces a 4-bit colour code for each pixel. The attribute picks two 3-bit colours, one for set bitmap bits and one for clear bits. A single brightness bit applies to both colours. A flash bit can exchange the two colours.

A colour exchange takes place only when the attribute's flash bit is set and an external flash-phase bit is also 1. Logic elsewhere toggles the flash-phase bit at the blink rate. This block samples it once per cell, when the cell is loaded.

The cell is loaded with a one-cycle strobe. The block then shifts out one pixel, most significant bit first, on each pixel-clock enable. A blanking input forces the code to zero. A valid output marks the cycles in which an unblanked cell pixel is on the output. Memory fetch, sync timing and the palette lookup sit outside this block.

Top module: `attr_pixel_gen`

## Requirements
- R1: A synchronous reset, active high, clears the bitmap, the attribute and the pixel count. While `pix_code` is 0 and `pix_valid` is 0, and until the next load.
- R2: A `load` edge captures `bitmap_in`. The pixel on the output right after that edge is bitmap bit 7. Each later clock edge with `pix_en` high advances by one bit toward bit 0. If `load` and `pix_en` are both high, `load` wins.
- R3: A bitmap bit of 1 selects the foreground colour, attribute bits 2..0. A bitmap bit of 0 selects the background colour, attribute bits 5..3. Within a colour field, bit 0 is blue, bit 1 is red and bit 2 is green.
- R4: `pix_code` is {bright, green, red, blue}. The bright bit is attribute bit 6 and applies to both foreground and background.
- R5: If attribute bit 7 and `flash_phase` are both 1 at the load edge, foreground and background are exchanged for the whole cell. Otherwise no exchange takes place.
- R6: A change of `flash_phase` between loads has no effect on the current cell.
- R7: While `blank` is 1, `pix_code` is 0 and `pix_valid` is 0. Shifting continues during blanking.
- R8: `pix_valid` is 1 from the load edge until the eighth `pix_en` edge of the cell, unless blanked. After that edge it is 0.
- R9: With `pix_en` and `load` both low, the displayed pixel does not change.
- R10: Changes of `attr_in` or `bitmap_in` without `load` have no effect on the current cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Cell load strobe |
| pix_en | input | 1 | Pixel-clock enable; advances one pixel |
| bitmap_in | input | 8 | Bitmap byte of the cell |
| attr_in | input | 8 | Attribute: [7] flash, [6] bright, [5:3] background, [2:0] foreground |
| flash_phase | input | 1 | External flash-phase control bit |
| blank | input | 1 | Blanking; forces the output to black |
| pix_code | output | 4 | {bright, G, R, B} colour code |
| pix_valid | output | 1 | Unblanked cell pixel present |

## Verification
The hardest case to reach from the ports is a flash-phase edge inside a cell. The stimulus has to flip `flash_phase` after a load and keep shifting. It must then show that the current cell keeps its colours and that the next load picks up the new phase. The stimulus does this in both directions: an exchange that must not start mid-cell, and one that must not stop mid-cell. Blanking during the middle of a cell is also tested. This shows that shifting went on underneath, because the pixel shown after unblanking is the one at the advanced position.

// File: rtl/apg_pkg.sv
package apg_pkg;
    localparam int COL_W  = 3;
    localparam int CODE_W = COL_W + 1;

    typedef logic [COL_W-1:0] colour_t;

    // Field order is fixed by the attribute byte layout.
    typedef struct packed {
        logic    flash;
        logic    bright;
        colour_t bg;
        colour_t fg;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    function automatic logic [CODE_W-1:0] make_code(input logic bright, input colour_t c);
        return {bright, c};
    endfunction
endpackage

// File: rtl/apg_shifter.sv
module apg_shifter #(
    parameter int PIX_W = 8,
    localparam int CNT_W = $clog2(PIX_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             pix_en,
    input  logic [PIX_W-1:0] bitmap_in,
    output logic             cur_bit,
    output logic             active,
    output logic [CNT_W-1:0] left
);
    typedef struct packed {
        logic [PIX_W-1:0] bits;
        logic [CNT_W-1:0] left;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.bits = bitmap_in;
            s_d.left = CNT_W'(PIX_W);
        end else if (pix_en && (s_q.left != '0)) begin
            s_d.bits = {s_q.bits[PIX_W-2:0], 1'b0};
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cur_bit = s_q.bits[PIX_W-1];
    assign active  = (s_q.left != '0);
    assign left    = s_q.left;
endmodule

// File: rtl/apg_attr_latch.sv
module apg_attr_latch
    import apg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  attr_t attr_in,
    input  logic  flash_phase,
    output attr_t attr,
    output logic  swap
);
    typedef struct packed {
        attr_t attr;
        logic  swap;
    } at_state_t;

    at_state_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (load) begin
            a_d.attr = attr_in;
            a_d.swap = attr_in.flash & flash_phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) a_q <= '0;
        else     a_q <= a_d;
    end

    assign attr = a_q.attr;
    assign swap = a_q.swap;
endmodule

// File: rtl/apg_colour_mux.sv
module apg_colour_mux
    import apg_pkg::*;
(
    input  logic              cur_bit,
    input  logic              active,
    input  logic              swap,
    input  attr_t             attr,
    input  logic              blank,
    output logic [CODE_W-1:0] code,
    output logic              valid
);
    logic    use_fg;
    colour_t sel;

    always_comb begin
        use_fg = cur_bit ^ swap;
        sel    = use_fg ? attr.fg : attr.bg;
        code   = blank ? '0 : make_code(attr.bright, sel);
        valid  = active & ~blank;
    end
endmodule

// File: rtl/attr_pixel_gen.sv
module attr_pixel_gen
    import apg_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int CNT_W = $clog2(PIX_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              pix_en,
    input  logic [PIX_W-1:0]  bitmap_in,
    input  logic [ATTR_W-1:0] attr_in,
    input  logic              flash_phase,
    input  logic              blank,
    output logic [CODE_W-1:0] pix_code,
    output logic              pix_valid
);
    logic             cur_bit;
    logic             active;
    logic [CNT_W-1:0] left;
    attr_t            attr_q;
    logic             swap_q;

    apg_shifter #(.PIX_W(PIX_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .pix_en    (pix_en),
        .bitmap_in (bitmap_in),
        .cur_bit   (cur_bit),
        .active    (active),
        .left      (left)
    );

    apg_attr_latch u_attr (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .attr_in     (attr_t'(attr_in)),
        .flash_phase (flash_phase),
        .attr        (attr_q),
        .swap        (swap_q)
    );

    apg_colour_mux u_mux (
        .cur_bit (cur_bit),
        .active  (active),
        .swap    (swap_q),
        .attr    (attr_q),
        .blank   (blank),
        .code    (pix_code),
        .valid   (pix_valid)
    );
endmodule

// File: rtl/apg_checker.sv
module apg_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             pix_en,
    input logic             blank,
    input logic [3:0]       pix_code,
    input logic             pix_valid,
    input logic             cur_bit,
    input logic [CNT_W-1:0] left,
    input logic [7:0]       attr_q,
    input logic             swap_q
);
    // R1: state cleared one edge after reset
    p_clear_r1: assert property (@(posedge clk)
        rst |=> (pix_code == 4'd0 && !pix_valid));

    // R7: blanking forces black and invalid
    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        blank |-> (pix_code == 4'd0 && !pix_valid));

    // R8: a load opens a valid cell
    p_load_valid_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (pix_valid || blank));

    // R9: no enable, no load: pixel position and value hold
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && !pix_en) |=> ($stable(cur_bit) && $stable(left)));

    // R6: exchange decision fixed between loads
    p_swap_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(swap_q));

    // R10: attribute held between loads
    p_attr_fixed_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(attr_q));
endmodule

bind attr_pixel_gen apg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .pix_en    (pix_en),
    .blank     (blank),
    .pix_code  (pix_code),
    .pix_valid (pix_valid),
    .cur_bit   (cur_bit),
    .left      (left),
    .attr_q    (attr_q),
    .swap_q    (swap_q)
);

// File: tb/attr_pixel_gen_test.sv
module attr_pixel_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic       pix_en = 1'b0;
    logic [7:0] bitmap_in = '0;
    logic [7:0] attr_in = '0;
    logic       flash_phase = 1'b0;
    logic       blank = 1'b0;
    logic [3:0] pix_code;
    logic       pix_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    attr_pixel_gen uut (
        .clk(clk), .rst(rst), .load(load), .pix_en(pix_en),
        .bitmap_in(bitmap_in), .attr_in(attr_in), .flash_phase(flash_phase),
        .blank(blank), .pix_code(pix_code), .pix_valid(pix_valid)
    );

    function automatic logic [3:0] ecode(input logic b, input logic [7:0] a, input logic sw);
        return {a[6], (b ^ sw) ? a[2:0] : a[5:3]};
    endfunction

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic ld, input logic en, input logic bl,
                       input logic [7:0] bm, input logic [7:0] at, input logic fp);
        load = ld; pix_en = en; blank = bl;
        bitmap_in = bm; attr_in = at; flash_phase = fp;
        @(negedge clk);
    endtask

    // Full cell with an enable every cycle (R2, R3, R4, R5, R8)
    task automatic t_cell(input logic [7:0] bm, input logic [7:0] at, input logic fp);
        logic sw;
        sw = at[7] & fp;
        cyc(1, 0, 0, bm, at, fp);
        for (int i = 0; i < 8; i++) begin
            chk("R2/R3/R4/R5 pixel", pix_code, ecode(bm[7-i], at, sw));
            chk("R8 valid in cell", {3'b0, pix_valid}, 4'd1);
            cyc(0, 1, 0, bm, at, fp);
        end
        chk("R8 valid after cell", {3'b0, pix_valid}, 4'd0);
    endtask

    task automatic t_reset_mid;
        cyc(1, 0, 0, 8'hFF, 8'h7F, 1'b0);
        cyc(0, 1, 0, 8'hFF, 8'h7F, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cyc(0, 1, 0, 8'hFF, 8'h7F, 1'b0);
        chk("R1 code after reset", pix_code, 4'd0);
        chk("R1 valid after reset", {3'b0, pix_valid}, 4'd0);
    endtask

    task automatic t_gap;
        logic [7:0] bm = 8'b1100_1010;
        logic [7:0] at = 8'b0_0_001_110;
        cyc(1, 0, 0, bm, at, 1'b0);
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 2; k++) begin
                chk("R9 hold", pix_code, ecode(bm[7-i], at, 1'b0));
                cyc(0, 0, 0, bm, at, 1'b0);
            end
            cyc(0, 1, 0, bm, at, 1'b0);
        end
        chk("R8 valid after gapped cell", {3'b0, pix_valid}, 4'd0);
    endtask

    task automatic t_flash_mid;
        logic [7:0] bm = 8'hF0;
        logic [7:0] at = 8'b1_1_110_011;
        cyc(1, 0, 0, bm, at, 1'b0);
        for (int i = 0; i < 8; i++) begin
            chk("R6 no swap starts mid-cell", pix_code, ecode(bm[7-i], at, 1'b0));
            cyc(0, 1, 0, bm, at, 1'b1);
        end
        cyc(1, 0, 0, bm, at, 1'b1);
        for (int i = 0; i < 8; i++) begin
            chk("R5/R6 swap kept mid-cell", pix_code, ecode(bm[7-i], at, 1'b1));
            cyc(0, 1, 0, bm, at, 1'b0);
        end
    endtask

    task automatic t_blank;
        logic [7:0] bm = 8'b1001_0001;
        logic [7:0] at = 8'b0_1_111_000;
        cyc(1, 0, 0, bm, at, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 1, 1, bm, at, 1'b0);
            chk("R7 blank code", pix_code, 4'd0);
            chk("R7 blank valid", {3'b0, pix_valid}, 4'd0);
        end
        cyc(0, 0, 0, bm, at, 1'b0);
        chk("R7 shifting under blank", pix_code, ecode(bm[4], at, 1'b0));
        chk("R7 valid after unblank", {3'b0, pix_valid}, 4'd1);
        cyc(0, 1, 0, bm, at, 1'b0);
        chk("R7 next pixel", pix_code, ecode(bm[3], at, 1'b0));
    endtask

    task automatic t_attr_hold;
        logic [7:0] bm = 8'b1010_0000;
        logic [7:0] at = 8'b0_1_100_010;
        cyc(1, 0, 0, bm, at, 1'b0);
        cyc(0, 0, 0, 8'h5F, 8'b1_0_011_101, 1'b1);
        chk("R10 attr held", pix_code, ecode(bm[7], at, 1'b0));
        cyc(0, 1, 0, 8'h5F, 8'b1_0_011_101, 1'b1);
        chk("R10 bitmap held", pix_code, ecode(bm[6], at, 1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset code", pix_code, 4'd0);
        chk("R1 reset valid", {3'b0, pix_valid}, 4'd0);
        cyc(0, 1, 0, 8'hFF, 8'hFF, 1'b1);
        chk("R1 black until load", pix_code, 4'd0);
        t_cell(8'hA5, 8'b0_1_010_101, 1'b0);  // R3 R4 bright
        t_cell(8'h3C, 8'b0_0_110_001, 1'b1);  // R4 dark, flash bit clear
        t_cell(8'hA5, 8'b1_1_010_101, 1'b1);  // R5 exchange
        t_cell(8'hA5, 8'b1_0_010_101, 1'b0);  // R5 phase low, no exchange
        t_gap;
        t_flash_mid;
        t_blank;
        t_attr_hold;
        t_reset_mid;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule